// File: doc/BRIEF.md
# Bus Cycle Controller with Hold and Backoff

This block runs single, non-burst read and write cycles on an external bus on behalf of an internal requester, and lets other masters take the bus from it in two ways. When a request is accepted, the controller drives the address for one clock with an address strobe. It then waits in a data phase for as many clocks as the external ready input stays low. When ready is sampled high, the controller returns a one-clock completion pulse and the captured read data.

A hold request is graceful. Any cycle in progress runs to completion, and then the controller floats its drivers and raises hold acknowledge. A backoff request is abortive. It floats the bus on the next edge, even if ready arrives on the same edge. The cancelled cycle is remembered and restarted from its address phase, with unchanged address, direction and data, once backoff is withdrawn.

A lock input from the requester keeps a read-modify-write pair together: while it is high, hold is not granted. While the controller does not own the bus, a bus request output tells the arbiter that it has work waiting. The requester holds its request fields stable until the completion pulse and drops its request in the cycle of that pulse.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset the controller is idle with bus_oe high, and ads, hold_ack, done and bus_req all low.
- R2: An accepted request produces ads high for exactly one clock, the edge after acceptance, with bus_addr, bus_write and bus_wdata equal to the request's fields.
- R3: The data phase lasts as long as bus_ready is sampled low, with done low. On the first edge that samples bus_ready high, done goes high for exactly one clock and rdata holds bus_rdata as sampled on that edge.
- R4: A hold request that arrives during a cycle does not disturb it: bus_oe stays high and the cycle still completes with done.
- R5: While hold_ack is high, bus_oe is low and ads stays low. Hold_ack rises on the edge that completes the cycle, or on the next edge when the controller is idle.
- R6: Hold_ack falls on the first edge that samples hold_req low, and bus_oe returns high one edge later.
- R7: Backoff sampled during the address or data phase floats the bus (bus_oe low) on that edge with no done, even if bus_ready is high on the same edge.
- R8: On the first edge that samples backoff low after an abort, the cycle restarts with ads and the same bus_addr, bus_write and bus_wdata, and then completes normally.
- R9: While lock_in is high, hold_ack is never raised. Once lock_in falls with hold_req still high, hold_ack rises on the next edge.
- R10: bus_req is high exactly when bus_oe is low and either an aborted cycle is pending or req_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Internal request present, held until done |
| req_addr | input | AW | Request address (8-byte granule) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| lock_in | input | 1 | Locked read-modify-write sequence in progress |
| bus_ready | input | 1 | External ready, ends the data phase |
| hold_req | input | 1 | Another master asks for the bus gracefully |
| backoff | input | 1 | Abort current cycle and float at once |
| bus_rdata | input | DW | Read data from the bus |
| ads | output | 1 | Address strobe, high in the address phase |
| bus_oe | output | 1 | Bus drivers enabled |
| bus_addr | output | AW | Address driven on the bus |
| bus_write | output | 1 | Direction driven on the bus |
| bus_wdata | output | DW | Write data driven on the bus |
| hold_ack | output | 1 | Bus released to another master |
| bus_req | output | 1 | Controller needs the bus while floated |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Read data captured at completion |

## Verification
Random read and write cycles with zero to four wait states and varying addresses and data separate correct wait-state counting and data capture from off-by-one ready sampling. Hold is applied both mid-cycle and while idle, which shows a graceful handover that finishes the cycle apart from one that cuts it short or delays release. Backoff is applied in the address phase and together with ready in the data phase, which distinguishes a true abort and faithful restart from a cycle that slips through or restarts with corrupted fields. A locked read-then-write pair with hold held high throughout shows whether the lock blocks the handover and whether release follows promptly once the lock falls.

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
  parameter int AW = 29,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          lock_in,
  input  logic          bus_ready,
  input  logic          hold_req,
  input  logic          backoff,
  input  logic [DW-1:0] bus_rdata,
  output logic          ads,
  output logic          bus_oe,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic [DW-1:0] bus_wdata,
  output logic          hold_ack,
  output logic          bus_req,
  output logic          done,
  output logic [DW-1:0] rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_HELD, S_REL, S_BOFF} st_t;

  st_t  state, nxt;
  logic pend;

  wire in_cycle = (state == S_ADDR) || (state == S_DATA);
  wire finish   = (state == S_DATA) && bus_ready && !backoff;
  wire grant_ok = hold_req && !lock_in;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (backoff) nxt = S_BOFF;
              else if (grant_ok) nxt = S_HELD;
              else if (req_valid && !done) nxt = S_ADDR;
      S_ADDR: nxt = backoff ? S_BOFF : S_DATA;
      S_DATA: if (backoff) nxt = S_BOFF;
              else if (bus_ready) nxt = grant_ok ? S_HELD : S_IDLE;
      S_HELD: if (!hold_req) nxt = S_REL;
      S_REL:  nxt = S_IDLE;
      S_BOFF: if (!backoff) nxt = pend ? S_ADDR : S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pend  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finish;
      if (in_cycle && backoff) pend <= 1'b1;
      else if (state == S_BOFF && !backoff) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
      rdata     <= '0;
    end else begin
      if (state == S_IDLE && nxt == S_ADDR) begin
        bus_addr  <= req_addr;
        bus_write <= req_write;
        bus_wdata <= req_wdata;
      end
      if (finish) rdata <= bus_rdata;
    end
  end

  assign ads      = (state == S_ADDR);
  assign bus_oe   = (state == S_IDLE) || in_cycle;
  assign hold_ack = (state == S_HELD);
  assign bus_req  = !bus_oe && (pend || req_valid);

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    ads |=> !ads);
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && hold_req && !bus_ready && !backoff) |=> bus_oe && !hold_ack);
  a_r5_ack_floats: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!bus_oe && !ads));
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> (!hold_ack && !bus_oe));
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cycle && backoff) |=> (!bus_oe && !done));
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BOFF && pend && !backoff) |=> (ads && $stable(bus_addr) && $stable(bus_wdata)));
  a_r9_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ack && lock_in) |=> !hold_ack);

endmodule

// File: tb/tb_bus_cycle_ctrl.sv
module tb_bus_cycle_ctrl;
  localparam int AW = 29;
  localparam int DW = 64;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, lock_in = 0, bus_ready = 0, hold_req = 0, backoff = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_rdata = '0;
  logic ads, bus_oe, bus_write, hold_ack, bus_req, done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, rdata;

  int tests = 0, fails = 0, cyc = 0;

  bus_cycle_ctrl #(.AW(AW), .DW(DW)) dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] mem_of(input logic [AW-1:0] a);
    return {~{3'b0, a}, {3'b0, a} ^ 32'h5A5A_0F0F};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // start a request; checks the address phase
  task automatic start_req(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d);
    req_valid = 1; req_addr = a; req_write = wr; req_wdata = d; bus_ready = 0;
    @(negedge clk);
    chk(ads === 1'b1, "R2 ads", ads, 1);
    chk(bus_addr === a && bus_write === wr && bus_wdata === d, "R2 fields", bus_addr, a);
    @(negedge clk);
    chk(ads === 1'b0, "R2 ads one clock", ads, 0);
  endtask

  // wait states then completion
  task automatic end_req(input int waits, input bit unlock);
    logic [AW-1:0] a = req_addr;
    for (int i = 0; i < waits; i++) begin
      chk(done === 1'b0 && bus_oe === 1'b1, "R3 wait state", done, 0);
      @(negedge clk);
    end
    bus_ready = 1; bus_rdata = mem_of(a);
    @(negedge clk);
    chk(done === 1'b1, "R3 done", done, 1);
    chk(rdata === mem_of(a), "R3 rdata", rdata, mem_of(a));
    bus_ready = 0; req_valid = 0; bus_rdata = '0;
    if (unlock) lock_in = 0;
    @(negedge clk);
    chk(done === 1'b0, "R3 done single", done, 0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_oe === 1 && ads === 0 && hold_ack === 0 && done === 0 && bus_req === 0, "R1 reset",
        {bus_oe, ads, hold_ack, done, bus_req}, 5'b10000);

    // directed: hold during a cycle
    start_req(29'h0123456, 0, '0);
    hold_req = 1;
    @(negedge clk);
    chk(bus_oe === 1 && hold_ack === 0, "R4 cycle continues under hold", {bus_oe, hold_ack}, 2'b10);
    bus_ready = 1; bus_rdata = mem_of(29'h0123456);
    @(negedge clk);
    chk(done === 1, "R4 done under hold", done, 1);
    chk(hold_ack === 1 && bus_oe === 0, "R5 ack after cycle", {hold_ack, bus_oe}, 2'b10);
    bus_ready = 0; req_valid = 1;
    @(negedge clk);
    chk(ads === 0 && hold_ack === 1, "R5 no strobe while held", {ads, hold_ack}, 2'b01);
    chk(bus_req === 1, "R10 req while held", bus_req, 1);
    req_valid = 0;
    @(negedge clk);
    chk(bus_req === 0, "R10 no req without work", bus_req, 0);
    hold_req = 0;
    @(negedge clk);
    chk(hold_ack === 0 && bus_oe === 0, "R6 ack drops", {hold_ack, bus_oe}, 2'b00);
    @(negedge clk);
    chk(bus_oe === 1, "R6 drivers back", bus_oe, 1);

    // hold while idle
    hold_req = 1;
    @(negedge clk);
    chk(hold_ack === 1 && bus_oe === 0, "R5 idle hold", {hold_ack, bus_oe}, 2'b10);
    hold_req = 0;
    @(negedge clk);
    @(negedge clk);

    // backoff in data phase together with ready
    start_req(29'h1ABCDE0, 1, 64'hDEAD_BEEF_0000_1111);
    bus_ready = 1; backoff = 1;
    @(negedge clk);
    chk(bus_oe === 0 && done === 0, "R7 abort with ready", {bus_oe, done}, 2'b00);
    chk(bus_req === 1, "R10 req after abort", bus_req, 1);
    bus_ready = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ads === 0 && bus_oe === 0, "R7 stays floated", {ads, bus_oe}, 2'b00);
    end
    backoff = 0;
    @(negedge clk);
    chk(ads === 1 && bus_addr === 29'h1ABCDE0 && bus_write === 1 && bus_wdata === 64'hDEAD_BEEF_0000_1111,
        "R8 restart fields", bus_addr, 29'h1ABCDE0);
    @(negedge clk);
    end_req(1, 0);

    // backoff in address phase
    req_valid = 1; req_addr = 29'h0000777; req_write = 0;
    @(negedge clk);
    backoff = 1;
    @(negedge clk);
    chk(bus_oe === 0 && done === 0, "R7 abort in address phase", {bus_oe, done}, 2'b00);
    backoff = 0;
    @(negedge clk);
    chk(ads === 1 && bus_addr === 29'h0000777, "R8 restart addr", bus_addr, 29'h0000777);
    @(negedge clk);
    end_req(2, 0);

    // locked read-modify-write with hold pending
    lock_in = 1; hold_req = 1;
    start_req(29'h0F0F0F0, 0, '0);
    end_req(1, 0);
    chk(hold_ack === 0 && bus_oe === 1, "R9 lock blocks hold after read", hold_ack, 0);
    start_req(29'h0F0F0F0, 1, 64'h1234);
    chk(hold_ack === 0, "R9 lock blocks hold during write", hold_ack, 0);
    end_req(0, 1);
    chk(hold_ack === 1, "R9 hold granted after unlock", hold_ack, 1);
    hold_req = 0;
    @(negedge clk);
    @(negedge clk);

    // random cycles
    void'($urandom(32'd2024));
    for (int n = 0; n < 150; n++) begin
      logic [AW-1:0] a = AW'($urandom);
      bit wr = 1'($urandom);
      logic [DW-1:0] d = {$urandom, $urandom};
      int w = $urandom % 5;
      start_req(a, wr, d);
      end_req(w, 0);
      if ($urandom % 4 == 0) begin
        hold_req = 1;
        @(negedge clk);
        chk(hold_ack === 1 && bus_oe === 0, "R5 random idle hold", hold_ack, 1);
        hold_req = 0;
        @(negedge clk);
        @(negedge clk);
        chk(bus_oe === 1, "R6 random release", bus_oe, 1);
      end
    end
    finish_run();
  end

  initial begin
    wait (cyc == 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    finish_run();
  end
endmodule